// File: doc/BRIEF.md
# Banked Core Memory Cycle Controller

This block runs one read-and-restore memory cycle of twelve timing pulses. A start request latches a 12-bit address and the current switchable-bank selection. The controller then decodes the address into an erasable bank, one of two fixed banks that are always visible, or a fixed bank named by the bank selection input. It reads the word into a 16-bit buffer at a pulse that depends on the kind of memory. It opens a window in which the processor may replace the buffer payload. After the window it writes the buffer back, so that the destructive read of erasable memory is restored.

Every stored word carries 15 payload bits and one odd-parity bit. The parity of each fetched word is checked, and a mismatch sets an alarm that stays set until it is cleared. A word that the processor changed is written back with freshly generated parity. A word left unchanged goes back exactly as it was read. Fixed banks are read-only, so no write strobe is issued for them.

Top module: `memcyc_ctrl`

## Requirements
- R1: After reset `tp` is 0, `busy` and `par_alarm` are 0, and neither `mem_rd_en` nor `mem_wr_en` is asserted.
- R2: A `start` sampled while idle (`tp` = 0) begins a cycle: `tp` then counts 1 to 12 over twelve clocks and returns to 0. `busy` is high while `tp` is nonzero, and `cycle_done` is high during pulse 12. A `start` sampled while busy is ignored.
- R3: The bank field is address bits [11:10] and the word offset is bits [9:0]. Field 00 gives erasable memory (`mem_fixed`=0, `mem_bank`=0). Field 01 gives fixed bank 1 and field 10 gives fixed bank 2. Field 11 gives a fixed bank equal to `bank_sel` as sampled at start. The decode is presented from pulse 1 to pulse 12.
- R4: For erasable memory `mem_rd_en` is high during pulse 5 only, and the fetched word is in `buf_word` from pulse 6.
- R5: For fixed memory `mem_rd_en` is high during pulse 6 only, and the fetched word is in `buf_word` from pulse 7.
- R6: `cpu_we` sampled during pulses 7 to 10 replaces the buffer payload with `cpu_wdata`, visible from the next pulse. `cpu_we` at any other pulse leaves the buffer and the written-back word unchanged.
- R7: For erasable memory `mem_wr_en` is high during pulse 11. `mem_wdata` is the fetched 16-bit word if the buffer was not written. If it was written, `mem_wdata` has the new payload in bits [14:0] and bit 15 set so that the total count of ones is odd.
- R8: For fixed memory `mem_wr_en` is never asserted.
- R9: A fetched word with an even count of ones sets `par_alarm` at its load pulse. The alarm then stays set through later cycles with good parity.
- R10: `clr_alarm` clears `par_alarm` on the next clock, and it takes priority over a detection at the same clock.
- R11: `win` is high during pulses 7 to 10 and low at every other pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timing pulse per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a memory cycle when idle |
| addr | input | 12 | Bank field and word offset, latched at start |
| bank_sel | input | 6 | Switchable fixed bank used for field 11, latched at start |
| cpu_we | input | 1 | Replace buffer payload (honoured in the window only) |
| cpu_wdata | input | 15 | New buffer payload |
| clr_alarm | input | 1 | Clear the parity alarm |
| tp | output | 4 | Current timing pulse, 0 when idle |
| busy | output | 1 | A cycle is in progress |
| cycle_done | output | 1 | Last pulse of the cycle |
| win | output | 1 | Processor access window is open |
| buf_word | output | 15 | Buffer payload |
| mem_fixed | output | 1 | Addressed memory is fixed (read-only) |
| mem_bank | output | 6 | Decoded bank number |
| mem_offset | output | 10 | Word offset inside the bank |
| mem_rd_en | output | 1 | Read strobe, data captured at the end of this pulse |
| mem_rdata | input | 16 | Word returned by memory, bit 15 parity |
| mem_wr_en | output | 1 | Write-back strobe for erasable memory |
| mem_wdata | output | 16 | Word written back, bit 15 parity |
| par_alarm | output | 1 | Sticky parity alarm |

## Verification
The cycle is exercised with all four bank fields, including two `bank_sel` values for the switchable field. Each field is tried with an unmodified pass and a modified pass, which separates the decode, the two read pulses and the suppressed fixed write-back. Erasable words are read back in a later cycle, so that a missing or wrong restore would show, because the memory model clears a word when it reads it. Payloads of all ones and all zeros separate a regenerated parity bit from a copied one. A planted bad-parity word, a following good cycle and a clear show detection, stickiness and clearing. Stray writes and starts outside the window show that they are ignored.

// File: rtl/memcyc_pkg.sv
package memcyc_pkg;
    localparam int WORD_W  = 15;
    localparam int OFF_W   = 10;
    localparam int BANK_W  = 6;
    localparam int FLD_W   = 2;
    localparam int ADDR_W  = OFF_W + FLD_W;
    localparam int STORE_W = WORD_W + 1;

    typedef enum logic [FLD_W-1:0] {
        FLD_ERAS   = 2'b00,
        FLD_FIX1   = 2'b01,
        FLD_FIX2   = 2'b10,
        FLD_SWITCH = 2'b11
    } bank_fld_e;

    typedef logic [WORD_W-1:0]  payload_t;
    typedef logic [STORE_W-1:0] stored_t;
    typedef logic [BANK_W-1:0]  bank_t;
    typedef logic [OFF_W-1:0]   off_t;
    typedef logic [ADDR_W-1:0]  addr_t;
endpackage

// File: rtl/memcyc_decode.sv
module memcyc_decode
    import memcyc_pkg::*;
(
    input  addr_t addr,
    input  bank_t sw_bank,
    output logic  is_fixed,
    output bank_t bank,
    output off_t  offset
);
    bank_fld_e fld;
    assign fld = bank_fld_e'(addr[ADDR_W-1 -: FLD_W]);

    always_comb begin
        offset = addr[OFF_W-1:0];
        unique case (fld)
            FLD_ERAS: begin
                is_fixed = 1'b0;
                bank     = '0;
            end
            FLD_FIX1: begin
                is_fixed = 1'b1;
                bank     = BANK_W'(1);
            end
            FLD_FIX2: begin
                is_fixed = 1'b1;
                bank     = BANK_W'(2);
            end
            default: begin
                is_fixed = 1'b1;
                bank     = sw_bank;
            end
        endcase
    end
endmodule

// File: rtl/memcyc_parity.sv
module memcyc_parity #(
    parameter int W = 15
) (
    input  logic [W-1:0] payload,
    output logic         odd_bit
);
    // bit that makes the count of ones over payload plus itself odd
    assign odd_bit = ~(^payload);
endmodule

// File: rtl/memcyc_seq.sv
module memcyc_seq #(
    parameter  int TP_COUNT = 12,
    localparam int TP_W     = $clog2(TP_COUNT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic [TP_W-1:0] tp,
    output logic            busy,
    output logic            last
);
    localparam logic [TP_W-1:0] TP_LAST = TP_W'(TP_COUNT);
    localparam logic [TP_W-1:0] TP_ONE  = TP_W'(1);

    typedef struct packed {
        logic [TP_W-1:0] tp;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.tp == '0) begin
            if (start) s_d.tp = TP_ONE;
        end else if (s_q.tp == TP_LAST) begin
            s_d.tp = '0;
        end else begin
            s_d.tp = s_q.tp + TP_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tp   = s_q.tp;
    assign busy = (s_q.tp != '0);
    assign last = (s_q.tp == TP_LAST);

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (tp == '0));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (tp == $past(tp) + TP_ONE));
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
endmodule

// File: rtl/memcyc_ctrl.sv
module memcyc_ctrl
    import memcyc_pkg::*;
#(
    parameter  int TP_COUNT      = 12,
    parameter  int ERAS_READY_TP = 6,
    parameter  int FIX_READY_TP  = 7,
    parameter  int WIN_FIRST     = 7,
    parameter  int WIN_LAST      = 10,
    localparam int TP_W          = $clog2(TP_COUNT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  addr_t           addr,
    input  bank_t           bank_sel,
    input  logic            cpu_we,
    input  payload_t        cpu_wdata,
    input  logic            clr_alarm,
    output logic [TP_W-1:0] tp,
    output logic            busy,
    output logic            cycle_done,
    output logic            win,
    output payload_t        buf_word,
    output logic            mem_fixed,
    output bank_t           mem_bank,
    output off_t            mem_offset,
    output logic            mem_rd_en,
    input  stored_t         mem_rdata,
    output logic            mem_wr_en,
    output stored_t         mem_wdata,
    output logic            par_alarm
);
    localparam int WB_TP = WIN_LAST + 1;
    localparam logic [TP_W-1:0] TP_RD_ERAS = TP_W'(ERAS_READY_TP - 1);
    localparam logic [TP_W-1:0] TP_RD_FIX  = TP_W'(FIX_READY_TP - 1);
    localparam logic [TP_W-1:0] TP_WIN_LO  = TP_W'(WIN_FIRST);
    localparam logic [TP_W-1:0] TP_WIN_HI  = TP_W'(WIN_LAST);
    localparam logic [TP_W-1:0] TP_WB      = TP_W'(WB_TP);

    typedef struct packed {
        addr_t   addr;
        bank_t   sw;
        stored_t buff;
        logic    mod;
        logic    alarm;
    } ctl_t;

    ctl_t c_d, c_q;

    logic rd_par_bit;
    logic wb_par_bit;
    logic rd_ok;

    memcyc_seq #(.TP_COUNT(TP_COUNT)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .tp    (tp),
        .busy  (busy),
        .last  (cycle_done)
    );

    memcyc_decode u_dec (
        .addr     (c_q.addr),
        .sw_bank  (c_q.sw),
        .is_fixed (mem_fixed),
        .bank     (mem_bank),
        .offset   (mem_offset)
    );

    memcyc_parity #(.W(WORD_W)) u_par_rd (
        .payload (mem_rdata[WORD_W-1:0]),
        .odd_bit (rd_par_bit)
    );

    memcyc_parity #(.W(WORD_W)) u_par_wb (
        .payload (c_q.buff[WORD_W-1:0]),
        .odd_bit (wb_par_bit)
    );

    assign rd_ok     = (rd_par_bit == mem_rdata[STORE_W-1]);
    assign mem_rd_en = busy && (tp == (mem_fixed ? TP_RD_FIX : TP_RD_ERAS));
    assign win       = (tp >= TP_WIN_LO) && (tp <= TP_WIN_HI);
    assign mem_wr_en = (tp == TP_WB) && !mem_fixed;
    assign mem_wdata = c_q.mod ? {wb_par_bit, c_q.buff[WORD_W-1:0]} : c_q.buff;
    assign buf_word  = c_q.buff[WORD_W-1:0];
    assign par_alarm = c_q.alarm;

    always_comb begin
        c_d = c_q;
        if (start && !busy) begin
            c_d.addr = addr;
            c_d.sw   = bank_sel;
            c_d.mod  = 1'b0;
        end
        if (mem_rd_en) begin
            c_d.buff = mem_rdata;
        end
        if (win && cpu_we) begin
            c_d.buff[WORD_W-1:0] = cpu_wdata;
            c_d.mod              = 1'b1;
        end
        if (clr_alarm) begin
            c_d.alarm = 1'b0;
        end else if (mem_rd_en && !rd_ok) begin
            c_d.alarm = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    p_reset_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !par_alarm && !mem_wr_en));

    p_rd_eras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !mem_fixed) |-> (tp == TP_RD_ERAS));
    p_rd_fix_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && mem_fixed) |-> (tp == TP_RD_FIX));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_en && !win) |=> $stable(buf_word));

    p_wb_odd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && c_q.mod) |-> (^mem_wdata));

    p_no_fixed_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (!mem_fixed && busy));

    p_detect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !rd_ok && !clr_alarm) |=> par_alarm);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (par_alarm && !clr_alarm) |=> par_alarm);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_alarm |=> !par_alarm);

    p_win_r11: assert property (@(posedge clk) disable iff (!rst_n)
        win |-> (busy && !mem_wr_en && !mem_rd_en));
endmodule

// File: tb/tb_memcyc_ctrl.sv
module tb_memcyc_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] addr = '0;
    logic [5:0]  bank_sel = '0;
    logic        cpu_we = 1'b0;
    logic [14:0] cpu_wdata = '0;
    logic        clr_alarm = 1'b0;
    logic [3:0]  tp;
    logic        busy, cycle_done, win, mem_fixed, mem_rd_en, mem_wr_en, par_alarm;
    logic [14:0] buf_word;
    logic [5:0]  mem_bank;
    logic [9:0]  mem_offset;
    logic [15:0] mem_rdata, mem_wdata;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;
    logic alarm_exp = 1'b0;

    logic [15:0] eram   [0:1023];
    logic [15:0] shadow [0:1023];

    always #(CLK_PERIOD/2) clk = ~clk;

    memcyc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .bank_sel(bank_sel),
        .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .clr_alarm(clr_alarm),
        .tp(tp), .busy(busy), .cycle_done(cycle_done), .win(win), .buf_word(buf_word),
        .mem_fixed(mem_fixed), .mem_bank(mem_bank), .mem_offset(mem_offset),
        .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata), .par_alarm(par_alarm)
    );

    function automatic logic [15:0] init_word(input logic [9:0] off);
        logic [14:0] p;
        logic        b;
        p = {off, off[4:0]} ^ 15'h1B3C;
        b = ~(^p);
        if (off == 10'h3FF) b = ~b;
        return {b, p};
    endfunction

    function automatic logic [15:0] fix_word(input logic [5:0] bk, input logic [9:0] off);
        logic [14:0] p;
        p = {bk, off[8:0]} ^ 15'h2A55;
        return {~(^p), p};
    endfunction

    // behavioural memories: erasable read clears the word, write-back restores it
    assign mem_rdata = mem_fixed ? fix_word(mem_bank, mem_offset) : eram[mem_offset];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) eram[i] <= init_word(10'(i));
        end else begin
            if (mem_rd_en && !mem_fixed) eram[mem_offset] <= 16'h0000;
            if (mem_wr_en) eram[mem_offset] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_cycle(input logic [11:0] a, input logic [5:0] br, input bit mdf,
                             input logic [14:0] wd, input bit stray);
        logic        efix;
        logic [5:0]  ebank;
        logic [15:0] orig, ewb;
        efix  = (a[11:10] != 2'b00);
        case (a[11:10])
            2'b00:   ebank = 6'd0;
            2'b01:   ebank = 6'd1;
            2'b10:   ebank = 6'd2;
            default: ebank = br;
        endcase
        orig = efix ? fix_word(ebank, a[9:0]) : shadow[a[9:0]];
        ewb  = mdf ? {~(^wd), wd} : orig;
        if (!(^orig)) alarm_exp = 1'b1;
        @(negedge clk);
        start = 1'b1; addr = a; bank_sel = br;
        @(negedge clk);
        if (!stray) start = 1'b0;
        for (int k = 1; k <= 12; k++) begin
            chk(tp == 4'(k), "R2 pulse count", 32'(tp), 32'(k));
            if (k == 1) begin
                chk(busy == 1'b1, "R2 busy", 32'(busy), 1);
                chk(mem_fixed == efix, "R3 fixed decode", 32'(mem_fixed), 32'(efix));
                chk(mem_bank == ebank, "R3 bank decode", 32'(mem_bank), 32'(ebank));
                chk(mem_offset == a[9:0], "R3 offset", 32'(mem_offset), 32'(a[9:0]));
            end
            if (stray && k == 4) begin
                cpu_we = 1'b1; cpu_wdata = 15'h5555;
            end
            if (stray && k == 6) start = 1'b0;
            if (k == 5) chk(mem_rd_en == !efix, "R4 erasable read pulse", 32'(mem_rd_en), 32'(!efix));
            if (k == 6) begin
                chk(mem_rd_en == efix, "R5 fixed read pulse", 32'(mem_rd_en), 32'(efix));
                if (!efix) chk(buf_word == orig[14:0], "R4 erasable ready", 32'(buf_word), 32'(orig[14:0]));
                chk(win == 1'b0, "R11 window closed before", 32'(win), 0);
            end
            if (k == 7) begin
                cpu_we = 1'b0;
                chk(win == 1'b1, "R11 window open", 32'(win), 1);
                chk(buf_word == orig[14:0], "R5 R6 fetched word", 32'(buf_word), 32'(orig[14:0]));
                chk(par_alarm == alarm_exp, "R9 alarm after load", 32'(par_alarm), 32'(alarm_exp));
                if (mdf) begin
                    cpu_we = 1'b1; cpu_wdata = wd;
                end
            end
            if (k == 8) begin
                cpu_we = 1'b0;
                if (mdf) chk(buf_word == wd, "R6 buffer modified", 32'(buf_word), 32'(wd));
            end
            if (k == 10) chk(win == 1'b1, "R11 window last pulse", 32'(win), 1);
            if (k == 11) begin
                chk(win == 1'b0, "R11 window closed after", 32'(win), 0);
                chk(mem_wr_en == !efix, "R7 R8 write strobe", 32'(mem_wr_en), 32'(!efix));
                if (!efix) chk(mem_wdata == ewb, "R7 write-back word", 32'(mem_wdata), 32'(ewb));
                if (stray) begin
                    cpu_we = 1'b1; cpu_wdata = 15'h2AAA;
                end
            end
            if (k == 12) begin
                chk(cycle_done == 1'b1, "R2 done", 32'(cycle_done), 1);
                chk(mem_wr_en == 1'b0, "R8 no late write", 32'(mem_wr_en), 0);
                cpu_we = 1'b0;
            end
            @(negedge clk);
        end
        chk(tp == 4'd0 && !busy, "R2 back to idle", 32'(tp), 0);
        if (!efix && mdf) shadow[a[9:0]] = ewb;
    endtask

    typedef struct packed {
        logic [11:0] a;
        logic [5:0]  br;
        logic        mdf;
        logic [14:0] wd;
    } vec_t;

    localparam vec_t VECS [0:9] = '{
        '{12'h005, 6'd0,  1'b0, 15'h0000},
        '{12'h005, 6'd0,  1'b1, 15'h1234},
        '{12'h005, 6'd9,  1'b0, 15'h0000},
        '{12'h40A, 6'd0,  1'b1, 15'h7777},
        '{12'h8FF, 6'd0,  1'b0, 15'h0000},
        '{12'hC33, 6'd5,  1'b0, 15'h0000},
        '{12'hC00, 6'd63, 1'b1, 15'h0101},
        '{12'h3FE, 6'd0,  1'b1, 15'h7FFF},
        '{12'h3FE, 6'd0,  1'b0, 15'h0000},
        '{12'h000, 6'd0,  1'b1, 15'h0000}
    };

    initial begin
        for (int i = 0; i < 1024; i++) shadow[i] = init_word(10'(i));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(tp == 4'd0 && !busy, "R1 idle at reset", 32'(tp), 0);
        chk(par_alarm == 1'b0, "R1 alarm at reset", 32'(par_alarm), 0);
        chk(!mem_rd_en && !mem_wr_en, "R1 strobes at reset", 32'({mem_rd_en, mem_wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tp == 4'd0 && !busy, "R1 idle after release", 32'(tp), 0);

        for (int v = 0; v < 10; v++) begin
            run_cycle(VECS[v].a, VECS[v].br, VECS[v].mdf, VECS[v].wd, 1'b0);
        end

        // R6 and R2: stray writes and starts outside the window, then read back
        run_cycle(12'h020, 6'd0, 1'b0, 15'h0000, 1'b1);
        run_cycle(12'h020, 6'd0, 1'b0, 15'h0000, 1'b0);

        // R9: bad-parity word sets the alarm, restored unchanged (R7)
        chk(par_alarm == 1'b0, "R9 alarm clear before bad word", 32'(par_alarm), 0);
        run_cycle(12'h3FF, 6'd0, 1'b0, 15'h0000, 1'b0);
        chk(par_alarm == 1'b1, "R9 alarm set", 32'(par_alarm), 1);
        // R9: sticky through a good cycle
        run_cycle(12'h401, 6'd0, 1'b0, 15'h0000, 1'b0);
        chk(par_alarm == 1'b1, "R9 alarm sticky", 32'(par_alarm), 1);

        // R10: explicit clear
        @(negedge clk);
        clr_alarm = 1'b1;
        @(negedge clk);
        clr_alarm = 1'b0;
        alarm_exp = 1'b0;
        chk(par_alarm == 1'b0, "R10 alarm cleared", 32'(par_alarm), 0);
        // R10: clear held across a bad-word load wins
        clr_alarm = 1'b1;
        alarm_exp = 1'b0;
        @(negedge clk);
        start = 1'b1; addr = 12'h3FF; bank_sel = 6'd0;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk(par_alarm == 1'b0, "R10 clear beats detection", 32'(par_alarm), 0);
        clr_alarm = 1'b0;
        repeat (6) @(negedge clk);
        chk(tp == 4'd0, "R2 idle after clear test", 32'(tp), 0);
        // word at 3FF was restored unchanged: reading it again raises the alarm
        run_cycle(12'h3FF, 6'd0, 1'b0, 15'h0000, 1'b0);
        chk(par_alarm == 1'b1, "R7 R9 bad word restored", 32'(par_alarm), 1);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL R2 watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule